// File: doc/BRIEF.md
# Serial Word Sync Command Link

This block carries alignment and IDLE add/drop commands over a single wire from one master device to every receiving device in a group, so that all of them act in the same word cycle. The transmitter half takes three request strobes from the master lane: a word sync event was seen, the next IDLE must be deleted, or an IDLE must be inserted. It turns each request into a three-bit code sent most significant bit first. The code is driven synchronously to the master word clock, and the line rests LOW when no command is pending.

The receiver half samples the line on the same word clock. It waits for a HIGH start bit, takes the next two bits as the command, and then raises exactly one one-cycle action strobe. Every device sees the same strobe timing. That includes the master, because its own line output is wired back to its line input. The add/drop itself therefore happens on the decoded strobe and not on the raw request. Requests that collide are served in a fixed priority. A request that arrives while a code is on the line is held until the line is free.

Transmitter states: TX_IDLE (line LOW; goes to TX_START when a request is pending), TX_START (drives the start bit and always goes to TX_B1), TX_B1 (drives the upper command bit and always goes to TX_B0), TX_B0 (drives the lower command bit and always goes to TX_GAP), and TX_GAP (line LOW for GAP_CYCLES cycles). When that count ends, TX_GAP goes to TX_START if a request is pending and to TX_IDLE otherwise. Receiver states: RX_HUNT (goes to RX_GOT_START on a HIGH sample), RX_GOT_START (stores the upper bit and always goes to RX_GOT_B1), and RX_GOT_B1 (decodes with the lower bit and always returns to RX_HUNT).

Top module: `wsync_link`

## Requirements
- R1: While no request is raised, line_out stays LOW, and with line_in held LOW no action strobe or error strobe is raised.
- R2: A sync request sampled at clock edge e0 puts the code 1,0,1 on line_out during the cycles after edges e0+1, e0+2 and e0+3 (start bit, then command bits 01).
- R3: A delete request is sent as the code 1,1,0 (command bits 10), with the same timing as R2.
- R4: An insert request is sent as the code 1,1,1 (command bits 11), with the same timing as R2.
- R5: The receiver raises the matching strobe (act_sync for 01, act_del for 10, act_ins for 11) for exactly one cycle, in the cycle after the third code bit. With line_out looped to line_in, this is the cycle after edge e0+4 for a request sampled at e0.
- R6: Requests pending together are sent in the order sync, then delete, then insert.
- R7: A request raised while a code is on the line is held pending and sent later. A repeat of a request that is already pending is merged into it and produces no second code.
- R8: Between two codes the line is LOW for GAP_CYCLES cycles. Back-to-back codes start exactly 3+GAP_CYCLES cycles apart.
- R9: If the two bits after a start bit are 00, the receiver raises proto_err for one cycle and raises no action strobe.
- R10: At most one of act_sync, act_del, act_ins and proto_err is HIGH in any cycle.
- R11: While rst_n is LOW, line_out and all strobes are LOW and all pending requests are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock shared by master and receivers |
| rst_n | input | 1 | Asynchronous reset, active LOW |
| req_sync | input | 1 | Master lane saw a word sync event |
| req_del | input | 1 | Request: delete the next IDLE |
| req_ins | input | 1 | Request: insert an IDLE after the next IDLE |
| line_out | output | 1 | Serial command line driven by this device |
| line_in | input | 1 | Serial command line sampled by this device |
| act_sync | output | 1 | One-cycle strobe: align to the sync event |
| act_del | output | 1 | One-cycle strobe: delete the next IDLE |
| act_ins | output | 1 | One-cycle strobe: insert after the next IDLE |
| proto_err | output | 1 | One-cycle strobe: start bit followed by 00 |

## Verification
The bench runs in loopback and applies all seven non-empty combinations of the three requests in a single cycle. In every cycle of each run it compares the strobes with a schedule computed from the priority order and the code period, which separates ordering faults from spacing faults. The first code of each run is also checked bit by bit on the line, which exposes a swapped code. Further runs raise a request in the middle of a code and repeat a request that is already pending, to show that requests are held and merged. With loopback opened, the bench drives hand-made codes onto line_in, including the 00 pattern, to check the receiver decode and the error strobe on their own.

// File: rtl/wsync_pkg.sv
package wsync_pkg;

    localparam int CMD_N    = 3;
    localparam int CMD_SYNC = 0;
    localparam int CMD_DEL  = 1;
    localparam int CMD_INS  = 2;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_B1,
        TX_B0,
        TX_GAP
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_GOT_START,
        RX_GOT_B1
    } rx_state_t;

    function automatic logic [1:0] cmd_bits(input int idx);
        logic [1:0] r;
        unique case (idx)
            CMD_SYNC: r = 2'b01;
            CMD_DEL:  r = 2'b10;
            default:  r = 2'b11;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wsync_prio.sv
module wsync_prio
    import wsync_pkg::*;
(
    input  logic [CMD_N-1:0] pend,
    output logic [CMD_N-1:0] grant,
    output logic [1:0]       bits
);

    always_comb begin
        grant = '0;
        bits  = 2'b00;
        for (int i = CMD_N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                bits     = cmd_bits(i);
            end
        end
    end

endmodule

// File: rtl/wsync_tx.sv
module wsync_tx
    import wsync_pkg::*;
#(
    parameter int GAP_CYCLES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_N-1:0] req,
    output logic             line_out
);

    localparam int GCNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [GCNT_W-1:0] GCNT_LAST = GCNT_W'(GAP_CYCLES - 1);

    tx_state_t         state_q, state_d;
    logic [CMD_N-1:0]  pend_q, pend_d;
    logic [CMD_N-1:0]  grant;
    logic [1:0]        sel_bits;
    logic [1:0]        code_q, code_d;
    logic [GCNT_W-1:0] gcnt_q, gcnt_d;
    logic              gap_done;
    logic              launch;

    wsync_prio u_prio (
        .pend  (pend_q),
        .grant (grant),
        .bits  (sel_bits)
    );

    assign gap_done = (gcnt_q == GCNT_LAST);
    assign launch   = (pend_q != '0) &&
                      ((state_q == TX_IDLE) || ((state_q == TX_GAP) && gap_done));

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        gcnt_d  = gcnt_q;
        pend_d  = (pend_q & ~(launch ? grant : '0)) | req;
        unique case (state_q)
            TX_IDLE: begin
                if (launch) begin
                    state_d = TX_START;
                    code_d  = sel_bits;
                end
            end
            TX_START: state_d = TX_B1;
            TX_B1:    state_d = TX_B0;
            TX_B0: begin
                state_d = TX_GAP;
                gcnt_d  = '0;
            end
            TX_GAP: begin
                if (gap_done) begin
                    if (launch) begin
                        state_d = TX_START;
                        code_d  = sel_bits;
                    end else begin
                        state_d = TX_IDLE;
                    end
                end else begin
                    gcnt_d = gcnt_q + 1'b1;
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            pend_q  <= '0;
            code_q  <= 2'b00;
            gcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            code_q  <= code_d;
            gcnt_q  <= gcnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            TX_START: line_out = 1'b1;
            TX_B1:    line_out = code_q[1];
            TX_B0:    line_out = code_q[0];
            default:  line_out = 1'b0;
        endcase
    end

    initial begin
        assert (GAP_CYCLES >= 1) else $error("GAP_CYCLES must be at least 1");
    end

    AST_GAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_B0) |=> !line_out); // R8

    AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && pend_q[CMD_SYNC]) |-> grant[CMD_SYNC]); // R6

    AST_DEL_OVER_INS: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !pend_q[CMD_SYNC] && pend_q[CMD_DEL]) |-> grant[CMD_DEL]); // R6

    AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> line_out); // R2

    generate
        for (genvar g = 0; g < CMD_N; g++) begin : g_hold
            AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_q[g] && !(launch && grant[g])) |=> pend_q[g]); // R7
        end
    endgenerate

endmodule

// File: rtl/wsync_rx.sv
module wsync_rx
    import wsync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic act_sync,
    output logic act_del,
    output logic act_ins,
    output logic proto_err
);

    rx_state_t state_q, state_d;
    logic      b1_q, b1_d;
    logic      fire;
    logic      sync_d, del_d, ins_d, err_d;

    always_comb begin
        state_d = state_q;
        b1_d    = b1_q;
        fire    = 1'b0;
        unique case (state_q)
            RX_HUNT: begin
                if (line_in) state_d = RX_GOT_START;
            end
            RX_GOT_START: begin
                b1_d    = line_in;
                state_d = RX_GOT_B1;
            end
            RX_GOT_B1: begin
                fire    = 1'b1;
                state_d = RX_HUNT;
            end
            default: state_d = RX_HUNT;
        endcase
    end

    always_comb begin
        sync_d = 1'b0;
        del_d  = 1'b0;
        ins_d  = 1'b0;
        err_d  = 1'b0;
        if (fire) begin
            unique case ({b1_q, line_in})
                2'b01:   sync_d = 1'b1;
                2'b10:   del_d  = 1'b1;
                2'b11:   ins_d  = 1'b1;
                default: err_d  = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= RX_HUNT;
            b1_q      <= 1'b0;
            act_sync  <= 1'b0;
            act_del   <= 1'b0;
            act_ins   <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            state_q   <= state_d;
            b1_q      <= b1_d;
            act_sync  <= sync_d;
            act_del   <= del_d;
            act_ins   <= ins_d;
            proto_err <= err_d;
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({act_sync, act_del, act_ins, proto_err}) <= 1); // R10

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sync || act_del || act_ins || proto_err)
        |=> !(act_sync || act_del || act_ins || proto_err)); // R5

    AST_ERR_ZERO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> !$past(line_in)); // R9

endmodule

// File: rtl/wsync_link.sv
module wsync_link
    import wsync_pkg::*;
#(
    parameter int GAP_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_sync,
    input  logic req_del,
    input  logic req_ins,
    output logic line_out,
    input  logic line_in,
    output logic act_sync,
    output logic act_del,
    output logic act_ins,
    output logic proto_err
);

    logic [CMD_N-1:0] req_vec;

    always_comb begin
        req_vec           = '0;
        req_vec[CMD_SYNC] = req_sync;
        req_vec[CMD_DEL]  = req_del;
        req_vec[CMD_INS]  = req_ins;
    end

    wsync_tx #(
        .GAP_CYCLES (GAP_CYCLES)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_vec),
        .line_out (line_out)
    );

    wsync_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .act_sync  (act_sync),
        .act_del   (act_del),
        .act_ins   (act_ins),
        .proto_err (proto_err)
    );

endmodule

// File: tb/wsync_link_bench.sv
module wsync_link_bench;

    localparam int GAP = 2;
    localparam int PER = 3 + GAP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_sync = 1'b0, req_del = 1'b0, req_ins = 1'b0;
    logic line_out, line_in, act_sync, act_del, act_ins, proto_err;
    logic loop_en = 1'b1;
    logic drv_line = 1'b0;
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign line_in = loop_en ? line_out : drv_line;

    wsync_link #(.GAP_CYCLES(GAP)) u_wsync_link (
        .clk(clk), .rst_n(rst_n),
        .req_sync(req_sync), .req_del(req_del), .req_ins(req_ins),
        .line_out(line_out), .line_in(line_in),
        .act_sync(act_sync), .act_del(act_del), .act_ins(act_ins),
        .proto_err(proto_err)
    );

    // strobe vector {sync, del, ins, err}
    task automatic chk4(input string req, input logic [3:0] got, input logic [3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s cyc=%0d strobes got=%b exp=%b", req, cyc, got, exp);
        end
    endtask

    task automatic chk1(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s cyc=%0d line got=%b exp=%b", req, cyc, got, exp);
        end
    endtask

    function automatic logic [3:0] strobes();
        return {act_sync, act_del, act_ins, proto_err};
    endfunction

    // n-th command of mask m (m[2]=sync, m[1]=del, m[0]=ins) in priority order, as strobe vector
    function automatic logic [3:0] nth_cmd(input logic [2:0] m, input int n);
        int k = 0;
        for (int b = 2; b >= 0; b--) begin
            if (m[b]) begin
                if (k == n) return 4'b0001 << (b + 1);
                k++;
            end
        end
        return 4'b0000;
    endfunction

    function automatic logic [1:0] code_of(input logic [3:0] s);
        if (s[3]) return 2'b01;
        if (s[2]) return 2'b10;
        return 2'b11;
    endfunction

    // R2 R3 R4 R5 R6 R8: all request combinations raised in one cycle
    task automatic run_combo(input logic [2:0] m);
        int c;
        logic [1:0] cb;
        logic [3:0] e;
        @(negedge clk);
        c = cyc;
        {req_sync, req_del, req_ins} = m;
        @(negedge clk);
        {req_sync, req_del, req_ins} = 3'b000;
        cb = code_of(nth_cmd(m, 0));
        for (int t = c + 1; t <= c + 5 + 3 * PER + 2; t++) begin
            if (t == c + 1) chk1("R2_line_pre", line_out, 1'b0);
            if (t == c + 2) chk1("R2_start", line_out, 1'b1);
            if (t == c + 3) chk1(m[2] ? "R2_b1" : (m[1] ? "R3_b1" : "R4_b1"), line_out, cb[1]);
            if (t == c + 4) chk1(m[2] ? "R2_b0" : (m[1] ? "R3_b0" : "R4_b0"), line_out, cb[0]);
            if (t == c + 5) chk1("R8_gap", line_out, 1'b0);
            e = 4'b0000;
            if (t >= c + 5 && ((t - c - 5) % PER) == 0) e = nth_cmd(m, (t - c - 5) / PER);
            chk4("R5_R6_R8_schedule", strobes(), e);
            @(negedge clk);
        end
    endtask

    task automatic drive_code(input logic [2:0] bits, input logic [3:0] exp, input string req);
        int c;
        @(negedge clk);
        c = cyc;
        for (int i = 2; i >= 0; i--) begin
            drv_line = bits[i];
            @(negedge clk);
        end
        drv_line = 1'b0;
        // third bit sampled at edge c+3; strobe visible at cyc c+3
        chk4(req, strobes(), exp);
        @(negedge clk);
        chk4({req, "_pulse"}, strobes(), 4'b0000);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk1("R11_line", line_out, 1'b0);
        chk4("R11_strobes", strobes(), 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 idle line
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk1("R1_line", line_out, 1'b0);
            chk4("R1_strobes", strobes(), 4'b0000);
        end
        for (int m = 1; m < 8; m++) begin
            run_combo(3'(m));
            repeat (4) @(negedge clk);
        end
        // R7: delete raised mid-code, then repeated while pending
        begin
            int c;
            @(negedge clk);
            c = cyc;
            req_sync = 1'b1;
            @(negedge clk);
            req_sync = 1'b0;
            @(negedge clk);
            req_del = 1'b1;
            @(negedge clk);
            @(negedge clk);
            req_del = 1'b0;
            for (int t = c + 4; t <= c + 5 + 3 * PER; t++) begin
                logic [3:0] e;
                e = 4'b0000;
                if (t == c + 5) e = 4'b1000;
                if (t == c + 5 + PER) e = 4'b0100;
                chk4("R7_hold_merge", strobes(), e);
                @(negedge clk);
            end
        end
        repeat (4) @(negedge clk);
        // R11: reset clears a pending request
        @(negedge clk);
        req_ins = 1'b1;
        @(negedge clk);
        req_ins = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk4("R11_in_reset", strobes(), 4'b0000);
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            chk1("R11_line_after", line_out, 1'b0);
            chk4("R11_no_action", strobes(), 4'b0000);
            @(negedge clk);
        end
        // receiver alone with hand-driven line
        loop_en = 1'b0;
        repeat (2) @(negedge clk);
        drive_code(3'b101, 4'b1000, "R5_rx_sync");
        drive_code(3'b110, 4'b0100, "R5_rx_del");
        drive_code(3'b111, 4'b0010, "R5_rx_ins");
        drive_code(3'b100, 4'b0001, "R9_err");
        drive_code(3'b101, 4'b1000, "R9_recover");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule